// File: doc/BRIEF.md
# MESI L1 Line Coherence Controller

This block tracks the coherence state of a single line in a private first-level cache that sits under a directory-kept MESI protocol. The surrounding cache logic looks up tags, decodes incoming processor and network messages into one event per cycle, and applies that event to the controller. The controller moves the line through its stable states (not present, invalid, shared, exclusive, modified). It also moves through the transient states a miss, an upgrade or a writeback passes through. For each event it answers with a set of one-cycle command strobes that the cache turns into network messages, processor completions or retries.

When a clean or dirty owned line is evicted, the line contents and dirty flag are copied into a one-entry writeback buffer. The line slot is freed at once. Until the writeback is acknowledged, invalidations and forwarded requests for that address are answered from the buffer. An invalidation that overtakes the data of a pending read lets the read finish but leaves the line invalid.

Strobes, data and state all change at the clock edge that consumes the event. They are visible for exactly the following cycle.

Top module: `mesi_line_ctrl`

## Requirements
- R1: Event codes on ev_i: 0 load, 1 fetch, 2 store, 3 replace, 4 invalidate, 5 forwarded GETS, 6 forwarded GETX, 7 forwarded GET_INSTR, 8 partial data, 9 exclusive data, 10 data with all acks, 11 ack, 12 last ack, 13 writeback ack. state_o codes: 0 NP, 1 I, 2 S, 3 E, 4 M, 5 IS, 6 IM, 7 SM, 8 IS_I, 9 M_I, 10 SINK_WB_ACK. After reset state_o is 0, every strobe is low and wb_valid_o is low.
- R2: A load, fetch, store or replace in any transient state (5 to 10) raises only retry_o and leaves state_o unchanged.
- R3: In NP or I, a load moves to IS with gets_o, a fetch moves to IS with get_instr_o, and a store moves to IM with getx_o.
- R4: An invalidate in NP or I raises only inv_ack_o and keeps the state; in S or E it raises only inv_ack_o and moves to I. A replace in NP, I or S moves to NP with no strobe.
- R5: A load or fetch in S, E or M raises only hit_o. A store in E or M raises only hit_o and ends in M. A store in S moves to SM with upgrade_o.
- R6: A replace in E or M raises putx_o, moves to M_I, and sets wb_valid_o. The line data and dirty flag are captured into the buffer. putx_dirty_o equals the line's dirty flag.
- R7: In M an invalidate sends data to L2 and moves to I. In E or M a forwarded GETS or GET_INSTR sends data to the requestor and to L2 and moves to S. A forwarded GETX sends data only to the requestor and moves to I. The data comes from line_data_i, with data_dirty_o equal to the line's dirty flag.
- R8: In M_I an invalidate (data to L2), a forwarded GETX (data to requestor) or a forwarded GETS/GET_INSTR (both) is served from the buffer: data_from_buf_o=1 and data_o equals the captured data. The state moves to SINK_WB_ACK. An invalidate in SINK_WB_ACK raises only inv_ack_o. A writeback ack clears wb_valid_o and ends in I from M_I and in NP from SINK_WB_ACK.
- R9: An invalidate in IS or IS_I raises inv_ack_o and moves to IS_I. Data (partial or all acks) in IS or IS_I raises hit_o and ends in S from IS and in I from IS_I. unblock_o is raised only when ev_from_l1_i is set.
- R10: Exclusive data in IS or IS_I raises hit_o and excl_unblock_o and ends in E, with the line's dirty flag taken from ev_dirty_i.
- R11: An invalidate in IM or SM raises inv_ack_o and ends in IM. Partial data in IM moves to SM. An ack in IM or SM changes nothing. Data with all acks in IM, or the last ack in SM, raises hit_o and excl_unblock_o and ends in M.
- R12: Strobes last one cycle per event. At most one request strobe (gets, get_instr, getx, upgrade, putx) and at most one of unblock_o/excl_unblock_o are high in a cycle. A cycle without ev_valid_i produces no strobe and no state change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ev_valid_i | input | 1 | An event is applied this cycle |
| ev_i | input | 4 | Event code (R1) |
| ev_from_l1_i | input | 1 | Data event was sent by another L1 |
| ev_dirty_i | input | 1 | Dirty flag carried by a data event |
| line_data_i | input | DATA_W | Current line contents from the data array |
| state_o | output | 4 | Line state code (R1) |
| gets_o | output | 1 | Issue GETS |
| get_instr_o | output | 1 | Issue GET_INSTR |
| getx_o | output | 1 | Issue GETX |
| upgrade_o | output | 1 | Issue UPGRADE |
| putx_o | output | 1 | Issue PUTX |
| putx_dirty_o | output | 1 | PUTX carries data size (line dirty) |
| data_req_o | output | 1 | Send data to the forwarded requestor |
| data_l2_o | output | 1 | Send data to L2 |
| data_from_buf_o | output | 1 | Sent data comes from the writeback buffer |
| data_o | output | DATA_W | Data payload for the send strobes |
| data_dirty_o | output | 1 | Dirty flag for the payload |
| inv_ack_o | output | 1 | Send invalidate ack |
| unblock_o | output | 1 | Send unblock |
| excl_unblock_o | output | 1 | Send exclusive unblock |
| hit_o | output | 1 | Processor access completes |
| retry_o | output | 1 | Processor request must be retried |
| wb_valid_o | output | 1 | Writeback buffer holds a line |

## Verification
The bench builds the controller with DATA_W set to 32, so the payload values it drives are short and easy to tell apart. Changing line_data_i between an eviction and a later forwarded request then shows directly whether data_o came from the buffer or from the live line. The event and state widths are fixed by the protocol, so every state and every transition named above is reachable with short directed sequences. These include the races in which an invalidation overtakes read data and a forwarded request meets a pending writeback.

// File: rtl/mesi_line_pkg.sv
package mesi_line_pkg;
  localparam int unsigned ST_W = 4;
  localparam int unsigned EV_W = 4;

  typedef enum logic [ST_W-1:0] {
    ST_NP   = 4'd0,
    ST_I    = 4'd1,
    ST_S    = 4'd2,
    ST_E    = 4'd3,
    ST_M    = 4'd4,
    ST_IS   = 4'd5,
    ST_IM   = 4'd6,
    ST_SM   = 4'd7,
    ST_IS_I = 4'd8,
    ST_M_I  = 4'd9,
    ST_SINK = 4'd10
  } line_st_e;

  typedef enum logic [EV_W-1:0] {
    EV_LOAD      = 4'd0,
    EV_FETCH     = 4'd1,
    EV_STORE     = 4'd2,
    EV_REPL      = 4'd3,
    EV_INV       = 4'd4,
    EV_FWD_GETS  = 4'd5,
    EV_FWD_GETX  = 4'd6,
    EV_FWD_INSTR = 4'd7,
    EV_DATA      = 4'd8,
    EV_DATA_EXCL = 4'd9,
    EV_DATA_ALL  = 4'd10,
    EV_ACK       = 4'd11,
    EV_ACK_ALL   = 4'd12,
    EV_WB_ACK    = 4'd13
  } line_ev_e;

  typedef struct packed {
    logic gets;
    logic get_instr;
    logic getx;
    logic upgrade;
    logic putx;
    logic data_req;
    logic data_l2;
    logic from_buf;
    logic inv_ack;
    logic unblock;
    logic excl_unblock;
    logic hit;
    logic retry;
  } line_cmd_t;

  function automatic logic is_transient(line_st_e s);
    return s inside {ST_IS, ST_IM, ST_SM, ST_IS_I, ST_M_I, ST_SINK};
  endfunction

  function automatic logic is_proc_ev(line_ev_e e);
    return e inside {EV_LOAD, EV_FETCH, EV_STORE, EV_REPL};
  endfunction
endpackage

// File: rtl/mesi_line_fsm.sv
module mesi_line_fsm
  import mesi_line_pkg::*;
(
  input  line_st_e  st_i,
  input  logic      ev_valid_i,
  input  line_ev_e  ev_i,
  input  logic      from_l1_i,
  output line_st_e  nxt_o,
  output line_cmd_t cmd_o,
  output logic      set_dirty_o,
  output logic      ld_dirty_o,
  output logic      clr_dirty_o,
  output logic      wb_load_o,
  output logic      wb_free_o
);

  always_comb begin
    nxt_o       = st_i;
    cmd_o       = '0;
    set_dirty_o = 1'b0;
    ld_dirty_o  = 1'b0;
    clr_dirty_o = 1'b0;
    wb_load_o   = 1'b0;
    wb_free_o   = 1'b0;
    if (ev_valid_i) begin
      if (is_proc_ev(ev_i) && is_transient(st_i)) begin
        cmd_o.retry = 1'b1;
      end else begin
        case (st_i)
          ST_NP, ST_I: begin
            case (ev_i)
              EV_LOAD:  begin nxt_o = ST_IS; cmd_o.gets = 1'b1; end
              EV_FETCH: begin nxt_o = ST_IS; cmd_o.get_instr = 1'b1; end
              EV_STORE: begin nxt_o = ST_IM; cmd_o.getx = 1'b1; end
              EV_REPL:  begin nxt_o = ST_NP; clr_dirty_o = 1'b1; end
              EV_INV:   cmd_o.inv_ack = 1'b1;
              default: ;
            endcase
          end
          ST_S: begin
            case (ev_i)
              EV_LOAD, EV_FETCH: cmd_o.hit = 1'b1;
              EV_STORE: begin nxt_o = ST_SM; cmd_o.upgrade = 1'b1; end
              EV_REPL:  begin nxt_o = ST_NP; clr_dirty_o = 1'b1; end
              EV_INV:   begin nxt_o = ST_I; cmd_o.inv_ack = 1'b1; clr_dirty_o = 1'b1; end
              default: ;
            endcase
          end
          ST_E, ST_M: begin
            case (ev_i)
              EV_LOAD, EV_FETCH: cmd_o.hit = 1'b1;
              EV_STORE: begin
                nxt_o       = ST_M;
                cmd_o.hit   = 1'b1;
                set_dirty_o = 1'b1;
              end
              EV_REPL: begin
                nxt_o       = ST_M_I;
                cmd_o.putx  = 1'b1;
                wb_load_o   = 1'b1;
                clr_dirty_o = 1'b1;
              end
              EV_INV: begin
                nxt_o       = ST_I;
                clr_dirty_o = 1'b1;
                if (st_i == ST_M) cmd_o.data_l2 = 1'b1;
                else              cmd_o.inv_ack = 1'b1;
              end
              EV_FWD_GETS, EV_FWD_INSTR: begin
                nxt_o          = ST_S;
                cmd_o.data_req = 1'b1;
                cmd_o.data_l2  = 1'b1;
                clr_dirty_o    = 1'b1;
              end
              EV_FWD_GETX: begin
                nxt_o          = ST_I;
                cmd_o.data_req = 1'b1;
                clr_dirty_o    = 1'b1;
              end
              default: ;
            endcase
          end
          ST_M_I: begin
            case (ev_i)
              EV_INV: begin
                nxt_o          = ST_SINK;
                cmd_o.data_l2  = 1'b1;
                cmd_o.from_buf = 1'b1;
              end
              EV_FWD_GETX: begin
                nxt_o          = ST_SINK;
                cmd_o.data_req = 1'b1;
                cmd_o.from_buf = 1'b1;
              end
              EV_FWD_GETS, EV_FWD_INSTR: begin
                nxt_o          = ST_SINK;
                cmd_o.data_req = 1'b1;
                cmd_o.data_l2  = 1'b1;
                cmd_o.from_buf = 1'b1;
              end
              EV_WB_ACK: begin nxt_o = ST_I; wb_free_o = 1'b1; end
              default: ;
            endcase
          end
          ST_SINK: begin
            case (ev_i)
              EV_INV:    cmd_o.inv_ack = 1'b1;
              EV_WB_ACK: begin nxt_o = ST_NP; wb_free_o = 1'b1; end
              default: ;
            endcase
          end
          ST_IS, ST_IS_I: begin
            case (ev_i)
              EV_INV: begin nxt_o = ST_IS_I; cmd_o.inv_ack = 1'b1; end
              EV_DATA, EV_DATA_ALL: begin
                nxt_o         = (st_i == ST_IS) ? ST_S : ST_I;
                cmd_o.hit     = 1'b1;
                cmd_o.unblock = from_l1_i;
                ld_dirty_o    = 1'b1;
              end
              EV_DATA_EXCL: begin
                nxt_o              = ST_E;
                cmd_o.hit          = 1'b1;
                cmd_o.excl_unblock = 1'b1;
                ld_dirty_o         = 1'b1;
              end
              default: ;
            endcase
          end
          ST_IM: begin
            case (ev_i)
              EV_INV:  cmd_o.inv_ack = 1'b1;
              EV_DATA: begin nxt_o = ST_SM; ld_dirty_o = 1'b1; end
              EV_DATA_ALL: begin
                nxt_o              = ST_M;
                cmd_o.hit          = 1'b1;
                cmd_o.excl_unblock = 1'b1;
                set_dirty_o        = 1'b1;
              end
              default: ;
            endcase
          end
          ST_SM: begin
            case (ev_i)
              EV_INV: begin nxt_o = ST_IM; cmd_o.inv_ack = 1'b1; end
              EV_ACK_ALL: begin
                nxt_o              = ST_M;
                cmd_o.hit          = 1'b1;
                cmd_o.excl_unblock = 1'b1;
                set_dirty_o        = 1'b1;
              end
              default: ;
            endcase
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/mesi_wb_buf.sv
module mesi_wb_buf #(
  parameter int unsigned DATA_W = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              free_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              dirty_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o,
  output logic              dirty_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      data_o  <= '0;
      dirty_o <= 1'b0;
    end else if (load_i) begin
      valid_o <= 1'b1;
      data_o  <= data_i;
      dirty_o <= dirty_i;
    end else if (free_i) begin
      valid_o <= 1'b0;
      dirty_o <= 1'b0;
    end
  end

endmodule

// File: rtl/mesi_cmd_out.sv
module mesi_cmd_out
  import mesi_line_pkg::*;
#(
  parameter int unsigned DATA_W = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  line_cmd_t         cmd_i,
  input  logic [DATA_W-1:0] line_data_i,
  input  logic              line_dirty_i,
  input  logic [DATA_W-1:0] wb_data_i,
  input  logic              wb_dirty_i,
  output line_cmd_t         cmd_o,
  output logic              putx_dirty_o,
  output logic [DATA_W-1:0] data_o,
  output logic              data_dirty_o
);

  logic send_data;
  assign send_data = cmd_i.data_req | cmd_i.data_l2;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_o        <= '0;
      putx_dirty_o <= 1'b0;
      data_o       <= '0;
      data_dirty_o <= 1'b0;
    end else begin
      cmd_o        <= cmd_i;
      putx_dirty_o <= cmd_i.putx & line_dirty_i;
      if (send_data) begin
        data_o       <= cmd_i.from_buf ? wb_data_i  : line_data_i;
        data_dirty_o <= cmd_i.from_buf ? wb_dirty_i : line_dirty_i;
      end
    end
  end

endmodule

// File: rtl/mesi_line_ctrl.sv
module mesi_line_ctrl
  import mesi_line_pkg::*;
#(
  parameter int unsigned DATA_W = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ev_valid_i,
  input  logic [EV_W-1:0]   ev_i,
  input  logic              ev_from_l1_i,
  input  logic              ev_dirty_i,
  input  logic [DATA_W-1:0] line_data_i,
  output logic [ST_W-1:0]   state_o,
  output logic              gets_o,
  output logic              get_instr_o,
  output logic              getx_o,
  output logic              upgrade_o,
  output logic              putx_o,
  output logic              putx_dirty_o,
  output logic              data_req_o,
  output logic              data_l2_o,
  output logic              data_from_buf_o,
  output logic [DATA_W-1:0] data_o,
  output logic              data_dirty_o,
  output logic              inv_ack_o,
  output logic              unblock_o,
  output logic              excl_unblock_o,
  output logic              hit_o,
  output logic              retry_o,
  output logic              wb_valid_o
);

  line_st_e          state_q, state_d;
  line_cmd_t         cmd_d, cmd_q;
  logic              line_dirty_q;
  logic              set_dirty, ld_dirty, clr_dirty, wb_load, wb_free;
  logic [DATA_W-1:0] wb_data;
  logic              wb_dirty;

  mesi_line_fsm u_fsm (
    .st_i        (state_q),
    .ev_valid_i  (ev_valid_i),
    .ev_i        (line_ev_e'(ev_i)),
    .from_l1_i   (ev_from_l1_i),
    .nxt_o       (state_d),
    .cmd_o       (cmd_d),
    .set_dirty_o (set_dirty),
    .ld_dirty_o  (ld_dirty),
    .clr_dirty_o (clr_dirty),
    .wb_load_o   (wb_load),
    .wb_free_o   (wb_free)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_NP;
      line_dirty_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (set_dirty)      line_dirty_q <= 1'b1;
      else if (ld_dirty)  line_dirty_q <= ev_dirty_i;
      else if (clr_dirty) line_dirty_q <= 1'b0;
    end
  end

  mesi_wb_buf #(.DATA_W(DATA_W)) u_wb (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (wb_load),
    .free_i  (wb_free),
    .data_i  (line_data_i),
    .dirty_i (line_dirty_q),
    .valid_o (wb_valid_o),
    .data_o  (wb_data),
    .dirty_o (wb_dirty)
  );

  mesi_cmd_out #(.DATA_W(DATA_W)) u_out (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cmd_i        (cmd_d),
    .line_data_i  (line_data_i),
    .line_dirty_i (line_dirty_q),
    .wb_data_i    (wb_data),
    .wb_dirty_i   (wb_dirty),
    .cmd_o        (cmd_q),
    .putx_dirty_o (putx_dirty_o),
    .data_o       (data_o),
    .data_dirty_o (data_dirty_o)
  );

  assign state_o         = state_q;
  assign gets_o          = cmd_q.gets;
  assign get_instr_o     = cmd_q.get_instr;
  assign getx_o          = cmd_q.getx;
  assign upgrade_o       = cmd_q.upgrade;
  assign putx_o          = cmd_q.putx;
  assign data_req_o      = cmd_q.data_req;
  assign data_l2_o       = cmd_q.data_l2;
  assign data_from_buf_o = cmd_q.from_buf;
  assign inv_ack_o       = cmd_q.inv_ack;
  assign unblock_o       = cmd_q.unblock;
  assign excl_unblock_o  = cmd_q.excl_unblock;
  assign hit_o           = cmd_q.hit;
  assign retry_o         = cmd_q.retry;

endmodule

// File: rtl/mesi_line_chk.sv
module mesi_line_chk
  import mesi_line_pkg::*;
(
  input logic            clk_i,
  input logic            rst_ni,
  input logic [ST_W-1:0] state_o,
  input logic            gets_o,
  input logic            get_instr_o,
  input logic            getx_o,
  input logic            upgrade_o,
  input logic            putx_o,
  input logic            data_from_buf_o,
  input logic            unblock_o,
  input logic            excl_unblock_o,
  input logic            hit_o,
  input logic            retry_o,
  input logic            wb_valid_o
);

  logic in_wb;
  assign in_wb = (state_o == ST_M_I) || (state_o == ST_SINK);

  p_retry_holds_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    retry_o |-> (state_o == $past(state_o)) && !hit_o);

  p_putx_enters_mi_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    putx_o |-> (state_o == ST_M_I) && wb_valid_o);

  p_buf_tracks_state_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_valid_o == in_wb);

  p_buf_data_sink_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_from_buf_o |-> state_o == ST_SINK);

  p_excl_owner_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    excl_unblock_o |-> (state_o == ST_E) || (state_o == ST_M));

  p_one_request_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({gets_o, get_instr_o, getx_o, upgrade_o, putx_o}));

  p_one_unblock_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({unblock_o, excl_unblock_o}));

endmodule

bind mesi_line_ctrl mesi_line_chk u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .state_o         (state_o),
  .gets_o          (gets_o),
  .get_instr_o     (get_instr_o),
  .getx_o          (getx_o),
  .upgrade_o       (upgrade_o),
  .putx_o          (putx_o),
  .data_from_buf_o (data_from_buf_o),
  .unblock_o       (unblock_o),
  .excl_unblock_o  (excl_unblock_o),
  .hit_o           (hit_o),
  .retry_o         (retry_o),
  .wb_valid_o      (wb_valid_o)
);

// File: tb/mesi_line_ctrl_test.sv
module mesi_line_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 32;

  localparam logic [3:0] E_LOAD = 0, E_FETCH = 1, E_STORE = 2, E_REPL = 3, E_INV = 4,
    E_FGETS = 5, E_FGETX = 6, E_FINSTR = 7, E_DATA = 8, E_DEXCL = 9, E_DALL = 10,
    E_ACK = 11, E_ACKALL = 12, E_WBACK = 13;
  localparam logic [3:0] T_NP = 0, T_I = 1, T_S = 2, T_E = 3, T_M = 4, T_IS = 5,
    T_IM = 6, T_SM = 7, T_IS_I = 8, T_M_I = 9, T_SINK = 10;
  localparam logic [11:0] S_NONE = 12'h000, S_GETS = 12'h800, S_INSTR = 12'h400,
    S_GETX = 12'h200, S_UPG = 12'h100, S_PUTX = 12'h080, S_DREQ = 12'h040,
    S_DL2 = 12'h020, S_ACK = 12'h010, S_UNB = 12'h008, S_XUNB = 12'h004,
    S_HIT = 12'h002, S_RETRY = 12'h001;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ev_valid = 1'b0;
  logic [3:0]    ev = '0;
  logic          from_l1 = 1'b0;
  logic          dirty = 1'b0;
  logic [DW-1:0] line_data = '0;
  logic [3:0]    state;
  logic gets, get_instr, getx, upgrade, putx, putx_dirty, data_req, data_l2, from_buf;
  logic [DW-1:0] data;
  logic data_dirty, inv_ack, unblock, excl_unblock, hit, retry, wb_valid;
  logic [11:0] strb;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mesi_line_ctrl #(.DATA_W(DW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .ev_valid_i(ev_valid), .ev_i(ev),
    .ev_from_l1_i(from_l1), .ev_dirty_i(dirty), .line_data_i(line_data),
    .state_o(state), .gets_o(gets), .get_instr_o(get_instr), .getx_o(getx),
    .upgrade_o(upgrade), .putx_o(putx), .putx_dirty_o(putx_dirty),
    .data_req_o(data_req), .data_l2_o(data_l2), .data_from_buf_o(from_buf),
    .data_o(data), .data_dirty_o(data_dirty), .inv_ack_o(inv_ack),
    .unblock_o(unblock), .excl_unblock_o(excl_unblock), .hit_o(hit),
    .retry_o(retry), .wb_valid_o(wb_valid)
  );

  assign strb = {gets, get_instr, getx, upgrade, putx, data_req, data_l2,
                 inv_ack, unblock, excl_unblock, hit, retry};

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // called at a negedge; applies one event and samples one cycle later
  task automatic step(input logic [3:0] e, input bit l1, input bit d, input string tag,
                      input logic [3:0] exp_st, input logic [11:0] exp_s);
    ev = e; from_l1 = l1; dirty = d; ev_valid = 1'b1;
    @(negedge clk);
    ev_valid = 1'b0;
    chk(state == exp_st, tag, "state", 64'(state), 64'(exp_st));
    chk(strb == exp_s, tag, "strobes", 64'(strb), 64'(exp_s));
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    chk(state == T_NP, "R1", "state", 64'(state), 64'(T_NP));
    chk(strb == S_NONE, "R1", "strobes", 64'(strb), 0);
    chk(!wb_valid, "R1", "wb_valid", 64'(wb_valid), 0);
  endtask

  task automatic go_e(input bit d);
    do_reset();
    step(E_LOAD,  0, 0, "R3", T_IS, S_GETS);
    step(E_DEXCL, 0, d, "R10", T_E, S_HIT | S_XUNB);
  endtask

  task automatic go_m();
    go_e(0);
    step(E_STORE, 0, 0, "R5", T_M, S_HIT);
  endtask

  task automatic t_load_miss();
    do_reset();
    step(E_LOAD,  0, 0, "R3", T_IS, S_GETS);
    step(E_LOAD,  0, 0, "R2", T_IS, S_RETRY);
    step(E_STORE, 0, 0, "R2", T_IS, S_RETRY);
    step(E_DALL,  0, 0, "R9", T_S, S_HIT);
    step(E_FETCH, 0, 0, "R5", T_S, S_HIT);
    step(E_INV,   0, 0, "R4", T_I, S_ACK);
    step(E_STORE, 0, 0, "R3", T_IM, S_GETX);
  endtask

  task automatic t_fetch_excl();
    do_reset();
    step(E_INV,   0, 0, "R4", T_NP, S_ACK);
    step(E_FETCH, 0, 0, "R3", T_IS, S_INSTR);
    step(E_DEXCL, 0, 0, "R10", T_E, S_HIT | S_XUNB);
    step(E_STORE, 0, 0, "R5", T_M, S_HIT);
    step(E_LOAD,  0, 0, "R5", T_M, S_HIT);
    step(E_REPL,  0, 0, "R2", T_M_I, S_PUTX);
    step(E_FETCH, 0, 0, "R2", T_M_I, S_RETRY);
  endtask

  task automatic t_is_races();
    do_reset();
    step(E_LOAD, 0, 0, "R3", T_IS, S_GETS);
    step(E_INV,  0, 0, "R9", T_IS_I, S_ACK);
    step(E_INV,  0, 0, "R9", T_IS_I, S_ACK);
    step(E_DATA, 1, 0, "R9", T_I, S_HIT | S_UNB);
    step(E_LOAD, 0, 0, "R3", T_IS, S_GETS);
    step(E_DATA, 1, 0, "R9", T_S, S_HIT | S_UNB);
    step(E_REPL, 0, 0, "R4", T_NP, S_NONE);
    step(E_LOAD, 0, 0, "R3", T_IS, S_GETS);
    step(E_INV,  0, 0, "R10", T_IS_I, S_ACK);
    step(E_DEXCL, 0, 0, "R10", T_E, S_HIT | S_XUNB);
  endtask

  task automatic t_store_miss();
    do_reset();
    step(E_STORE, 0, 0, "R3", T_IM, S_GETX);
    step(E_ACK,   0, 0, "R11", T_IM, S_NONE);
    step(E_DATA,  0, 0, "R11", T_SM, S_NONE);
    step(E_ACK,   0, 0, "R11", T_SM, S_NONE);
    step(E_INV,   0, 0, "R11", T_IM, S_ACK);
    step(E_DALL,  0, 0, "R11", T_M, S_HIT | S_XUNB);
  endtask

  task automatic t_upgrade();
    do_reset();
    step(E_LOAD,   0, 0, "R3", T_IS, S_GETS);
    step(E_DATA,   0, 0, "R9", T_S, S_HIT);
    step(E_STORE,  0, 0, "R5", T_SM, S_UPG);
    step(E_REPL,   0, 0, "R2", T_SM, S_RETRY);
    step(E_ACKALL, 0, 0, "R11", T_M, S_HIT | S_XUNB);
  endtask

  task automatic t_wb_dirty();
    go_m();
    line_data = 32'hA5A5_0001;
    step(E_REPL, 0, 0, "R6", T_M_I, S_PUTX);
    chk(putx_dirty == 1'b1, "R6", "putx_dirty", 64'(putx_dirty), 1);
    chk(wb_valid == 1'b1, "R6", "wb_valid", 64'(wb_valid), 1);
    line_data = 32'h0BAD_0BAD;
    step(E_FGETS, 0, 0, "R8", T_SINK, S_DREQ | S_DL2);
    chk(data == 32'hA5A5_0001, "R8", "data", 64'(data), 64'h A5A5_0001);
    chk(from_buf && data_dirty, "R8", "buf/dirty", 64'({from_buf, data_dirty}), 3);
    step(E_INV,   0, 0, "R8", T_SINK, S_ACK);
    step(E_WBACK, 0, 0, "R8", T_NP, S_NONE);
    chk(!wb_valid, "R8", "wb_valid", 64'(wb_valid), 0);
  endtask

  task automatic t_wb_clean();
    go_e(0);
    line_data = 32'h1234_5678;
    step(E_REPL, 0, 0, "R6", T_M_I, S_PUTX);
    chk(putx_dirty == 1'b0, "R6", "putx_dirty", 64'(putx_dirty), 0);
    line_data = 32'hFFFF_0000;
    step(E_INV, 0, 0, "R8", T_SINK, S_DL2);
    chk(data == 32'h1234_5678 && from_buf, "R8", "data", 64'(data), 64'h1234_5678);
    do_reset();
    go_e(1);
    step(E_REPL,  0, 0, "R6", T_M_I, S_PUTX);
    chk(putx_dirty == 1'b1, "R10", "putx_dirty from data", 64'(putx_dirty), 1);
    step(E_FGETX, 0, 0, "R8", T_SINK, S_DREQ);
    go_e(0);
    step(E_REPL,  0, 0, "R6", T_M_I, S_PUTX);
    step(E_WBACK, 0, 0, "R8", T_I, S_NONE);
    chk(!wb_valid, "R8", "wb_valid", 64'(wb_valid), 0);
  endtask

  task automatic t_forwards();
    go_m();
    line_data = 32'hCAFE_0007;
    step(E_FGETX, 0, 0, "R7", T_I, S_DREQ);
    chk(data == 32'hCAFE_0007 && !from_buf && data_dirty, "R7", "data",
        64'(data), 64'hCAFE_0007);
    go_e(0);
    step(E_FINSTR, 0, 0, "R7", T_S, S_DREQ | S_DL2);
    chk(!data_dirty, "R7", "data_dirty", 64'(data_dirty), 0);
    go_m();
    step(E_FGETS, 0, 0, "R7", T_S, S_DREQ | S_DL2);
    go_m();
    step(E_INV, 0, 0, "R7", T_I, S_DL2);
    step(E_REPL, 0, 0, "R4", T_NP, S_NONE);
    go_e(0);
    step(E_INV, 0, 0, "R4", T_I, S_ACK);
  endtask

  task automatic t_single_cycle();
    go_e(0);
    @(negedge clk);
    chk(strb == S_NONE, "R12", "idle strobes", 64'(strb), 0);
    chk(state == T_E, "R12", "idle state", 64'(state), 64'(T_E));
    ev = E_STORE;
    @(negedge clk);
    chk(state == T_E && strb == S_NONE, "R12", "no valid", 64'(state), 64'(T_E));
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    t_reset();
    t_load_miss();
    t_fetch_excl();
    t_is_races();
    t_store_miss();
    t_upgrade();
    t_wb_dirty();
    t_wb_clean();
    t_forwards();
    t_single_cycle();
    done = 1;
    summary();
    $finish;
  end
endmodule